// File: doc/BRIEF.md
# Received Frame Address Filter

This block sits on the receive side of an Ethernet datapath. It watches a stream of 16-bit words that carries whole frames, with a start mark on the first word and an end mark on the last. From the header it decides whether the frame is meant for this station: the destination has to be the local address, or the broadcast address when broadcasts are allowed. The source has to be the expected peer unless any source is allowed, and the ethertype has to match the configured value. An 802.1Q tag, if present, is skipped before the ethertype is compared.

Each frame gives one decision pulse carrying accept or drop. For an accepted frame, the words after the ethertype come out one cycle later with their own start and end marks. A dropped frame produces nothing on the payload port. Two complete configuration sets are present: one driven by application logic and one held in registers. A select input picks the register set in place of the application set.

Top module: `rxf_filter`

## Requirements
- R1: After reset, with no input, `out_valid` and `dec_valid` stay low.
- R2: Input words are counted only while `in_valid` is high. A frame whose first three words (most significant first) equal the selected local MAC passes the destination test.
- R3: A destination of all ones (FFFF FFFF FFFF) passes the destination test only while the selected broadcast-accept flag is 1. Any other destination that differs from the local MAC fails.
- R4: When the selected any-source flag is 0, words 3 to 5 must equal the selected remote MAC. When it is 1, the source address is not checked.
- R5: The ethertype word must equal the selected ethertype, or the frame is dropped.
- R6: Each frame yields exactly one `dec_valid` pulse. It comes in the cycle after the ethertype word is taken, and `dec_accept` is high only in that pulse and only for an accepted frame.
- R7: If the word after the source address is 0x8100, it and the following tag control word are skipped, and the next word is compared as the ethertype. A second 0x8100 in that position is compared as a plain ethertype.
- R8: For an accepted frame, each later input word appears on `out_data` with `out_valid` one cycle after it is taken. `out_sof` is set on the first such word and `out_eof` on the word that carried `in_eof`.
- R9: A dropped frame drives `out_valid` low for all of its words. The next `in_sof` re-arms the filter.
- R10: When `reg_override` is 1, the local MAC, remote MAC, ethertype and both flags all come from the `reg_*` inputs. When it is 0, they all come from the `cfg_*` inputs.
- R11: A frame that ends before its ethertype word gives a drop decision in the cycle after its last word, and no payload.
- R12: An `in_sof` in the middle of a frame abandons that frame and starts parsing a new header from that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Input word, network byte order |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| cfg_local_mac | input | 48 | Application local MAC |
| cfg_remote_mac | input | 48 | Application expected source MAC |
| cfg_ethertype | input | 16 | Application ethertype |
| cfg_accept_bcast | input | 1 | Application broadcast-accept flag |
| cfg_any_source | input | 1 | Application any-source flag |
| reg_override | input | 1 | Select the register configuration set |
| reg_local_mac | input | 48 | Register local MAC |
| reg_remote_mac | input | 48 | Register expected source MAC |
| reg_ethertype | input | 16 | Register ethertype |
| reg_accept_bcast | input | 1 | Register broadcast-accept flag |
| reg_any_source | input | 1 | Register any-source flag |
| out_valid | output | 1 | Payload word qualifier |
| out_data | output | 16 | Payload word of an accepted frame |
| out_sof | output | 1 | First payload word |
| out_eof | output | 1 | Last payload word |
| dec_valid | output | 1 | Per-frame decision pulse |
| dec_accept | output | 1 | Decision value, 1 for accept |

## Verification
The assertions check on every cycle that payload appears only after an accepting decision and before the frame ends. They also check that each output word equals the input word of the previous cycle, that the first payload word carries the start mark, and that the decision value never appears without its pulse. Whether a given decision is correct depends on the address, flag, tag and override combination. Only the bench's sweep can show this, by comparing each decision and each payload word with a value it derives from the header it built. The bench scenarios also cover truncated headers and restarts in the middle of a frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TAG  = 3'd2,
        PH_TYPE = 3'd3,
        PH_PAY  = 3'd4,
        PH_DROP = 3'd5
    } phase_e;

endpackage

// File: rtl/rxf_cfg_sel.sv
module rxf_cfg_sel #(
    parameter int MAC_W  = 48,
    parameter int TYPE_W = 16
) (
    input  logic              use_reg,
    input  logic [MAC_W-1:0]  a_local,
    input  logic [MAC_W-1:0]  a_remote,
    input  logic [TYPE_W-1:0] a_type,
    input  logic              a_bcast,
    input  logic              a_any,
    input  logic [MAC_W-1:0]  b_local,
    input  logic [MAC_W-1:0]  b_remote,
    input  logic [TYPE_W-1:0] b_type,
    input  logic              b_bcast,
    input  logic              b_any,
    output logic [MAC_W-1:0]  s_local,
    output logic [MAC_W-1:0]  s_remote,
    output logic [TYPE_W-1:0] s_type,
    output logic              s_bcast,
    output logic              s_any
);
    // whole-set switch: never mixes fields of the two sets
    always_comb begin
        if (use_reg) begin
            s_local  = b_local;
            s_remote = b_remote;
            s_type   = b_type;
            s_bcast  = b_bcast;
            s_any    = b_any;
        end else begin
            s_local  = a_local;
            s_remote = a_remote;
            s_type   = a_type;
            s_bcast  = a_bcast;
            s_any    = a_any;
        end
    end
endmodule

// File: rtl/rxf_word_cmp.sv
module rxf_word_cmp #(
    parameter int DATA_W = 16,
    parameter int MAC_W  = 48,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] word,
    input  logic [MAC_W-1:0]  mac,
    input  logic [IDX_W-1:0]  idx,
    output logic              eq
);
    localparam int WORDS = MAC_W / DATA_W;

    // word 0 is the most significant slice (network order)
    always_comb begin
        eq = 1'b0;
        for (int w = 0; w < WORDS; w++) begin
            if (idx == IDX_W'(w)) begin
                eq = (word == mac[(WORDS-1-w)*DATA_W +: DATA_W]);
            end
        end
    end
endmodule

// File: rtl/rxf_parse.sv
module rxf_parse
    import rxf_pkg::*;
#(
    parameter int               DATA_W    = 16,
    parameter int               MAC_W     = 48,
    parameter int               TAG_WORDS = 1,
    parameter logic [DATA_W-1:0] TPID     = 16'h8100,
    parameter int               IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] sel_type,
    input  logic              sel_bcast,
    input  logic              sel_any,
    input  logic              loc_eq,
    input  logic              rem_eq,
    output logic [IDX_W-1:0]  loc_idx,
    output logic [IDX_W-1:0]  rem_idx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int MACW   = MAC_W / DATA_W;
    localparam int TAG_CW = $clog2(TAG_WORDS + 1);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [TAG_CW-1:0]   tag_cnt;
        logic                tag_done;
        logic                dst_loc;
        logic                dst_bc;
        logic                src_ok;
        logic                first;
        logic                out_valid;
        logic [DATA_W-1:0]   out_data;
        logic                out_sof;
        logic                out_eof;
        logic                dec_valid;
        logic                dec_accept;
    } st_t;

    st_t q, d;
    logic verdict;

    assign loc_idx = in_sof ? '0 : q.idx;
    assign rem_idx = q.idx - IDX_W'(MACW);
    assign verdict = (q.dst_loc | (sel_bcast & q.dst_bc)) &
                     (sel_any | q.src_ok) & (in_data == sel_type);

    always_comb begin
        d            = q;
        d.out_valid  = 1'b0;
        d.out_sof    = 1'b0;
        d.out_eof    = 1'b0;
        d.dec_valid  = 1'b0;
        d.dec_accept = 1'b0;
        if (in_valid) begin
            if (in_sof) begin
                d.phase    = PH_ADDR;
                d.idx      = IDX_W'(1);
                d.tag_cnt  = '0;
                d.tag_done = 1'b0;
                d.dst_loc  = loc_eq;
                d.dst_bc   = &in_data;
                d.src_ok   = 1'b1;
                d.first    = 1'b0;
                if (in_eof) begin
                    d.dec_valid = 1'b1;
                    d.phase     = PH_IDLE;
                end
            end else begin
                unique case (q.phase)
                    PH_ADDR: begin
                        if (q.idx < IDX_W'(MACW)) begin
                            d.dst_loc = q.dst_loc & loc_eq;
                            d.dst_bc  = q.dst_bc & (&in_data);
                        end else begin
                            d.src_ok = q.src_ok & rem_eq;
                        end
                        d.idx = q.idx + IDX_W'(1);
                        if (q.idx == IDX_W'(2*MACW-1)) d.phase = PH_TYPE;
                        if (in_eof) begin
                            d.dec_valid = 1'b1;
                            d.phase     = PH_IDLE;
                        end
                    end
                    PH_TYPE: begin
                        if (!q.tag_done && in_data == TPID) begin
                            d.phase   = in_eof ? PH_IDLE : PH_TAG;
                            d.tag_cnt = '0;
                            d.dec_valid = in_eof;
                        end else begin
                            d.dec_valid  = 1'b1;
                            d.dec_accept = verdict;
                            d.first      = 1'b1;
                            if (in_eof)       d.phase = PH_IDLE;
                            else if (verdict) d.phase = PH_PAY;
                            else              d.phase = PH_DROP;
                        end
                    end
                    PH_TAG: begin
                        d.tag_cnt = q.tag_cnt + TAG_CW'(1);
                        if (q.tag_cnt == TAG_CW'(TAG_WORDS-1)) begin
                            d.phase    = PH_TYPE;
                            d.tag_done = 1'b1;
                        end
                        if (in_eof) begin
                            d.dec_valid = 1'b1;
                            d.phase     = PH_IDLE;
                        end
                    end
                    PH_PAY: begin
                        d.out_valid = 1'b1;
                        d.out_data  = in_data;
                        d.out_sof   = q.first;
                        d.first     = 1'b0;
                        if (in_eof) begin
                            d.out_eof = 1'b1;
                            d.phase   = PH_IDLE;
                        end
                    end
                    PH_DROP: begin
                        if (in_eof) d.phase = PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid  = q.out_valid;
    assign out_data   = q.out_data;
    assign out_sof    = q.out_sof;
    assign out_eof    = q.out_eof;
    assign dec_valid  = q.dec_valid;
    assign dec_accept = q.dec_accept;
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter #(
    parameter int                DATA_W    = 16,
    parameter int                MAC_W     = 48,
    parameter int                TAG_WORDS = 1,
    parameter logic [DATA_W-1:0] TPID      = 16'h8100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [MAC_W-1:0]  cfg_local_mac,
    input  logic [MAC_W-1:0]  cfg_remote_mac,
    input  logic [DATA_W-1:0] cfg_ethertype,
    input  logic              cfg_accept_bcast,
    input  logic              cfg_any_source,
    input  logic              reg_override,
    input  logic [MAC_W-1:0]  reg_local_mac,
    input  logic [MAC_W-1:0]  reg_remote_mac,
    input  logic [DATA_W-1:0] reg_ethertype,
    input  logic              reg_accept_bcast,
    input  logic              reg_any_source,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int MACW  = MAC_W / DATA_W;
    localparam int IDX_W = $clog2(2*MACW + 1);

    logic [MAC_W-1:0]  s_local, s_remote;
    logic [DATA_W-1:0] s_type;
    logic              s_bcast, s_any;
    logic [IDX_W-1:0]  loc_idx, rem_idx;
    logic              loc_eq, rem_eq;

    rxf_cfg_sel #(.MAC_W(MAC_W), .TYPE_W(DATA_W)) u_sel (
        .use_reg (reg_override),
        .a_local (cfg_local_mac),  .a_remote(cfg_remote_mac), .a_type(cfg_ethertype),
        .a_bcast (cfg_accept_bcast), .a_any(cfg_any_source),
        .b_local (reg_local_mac),  .b_remote(reg_remote_mac), .b_type(reg_ethertype),
        .b_bcast (reg_accept_bcast), .b_any(reg_any_source),
        .s_local (s_local), .s_remote(s_remote), .s_type(s_type),
        .s_bcast (s_bcast), .s_any(s_any)
    );

    rxf_word_cmp #(.DATA_W(DATA_W), .MAC_W(MAC_W), .IDX_W(IDX_W)) u_cmp_loc (
        .word(in_data), .mac(s_local), .idx(loc_idx), .eq(loc_eq)
    );

    rxf_word_cmp #(.DATA_W(DATA_W), .MAC_W(MAC_W), .IDX_W(IDX_W)) u_cmp_rem (
        .word(in_data), .mac(s_remote), .idx(rem_idx), .eq(rem_eq)
    );

    rxf_parse #(
        .DATA_W(DATA_W), .MAC_W(MAC_W), .TAG_WORDS(TAG_WORDS), .TPID(TPID), .IDX_W(IDX_W)
    ) u_parse (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .sel_type(s_type), .sel_bcast(s_bcast), .sel_any(s_any),
        .loc_eq(loc_eq), .rem_eq(rem_eq),
        .loc_idx(loc_idx), .rem_idx(rem_idx),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eof,
    input logic              dec_valid,
    input logic              dec_accept
);
    logic open_q, started_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            started_q <= 1'b0;
        end else if (dec_valid) begin
            open_q    <= dec_accept;
            started_q <= 1'b0;
        end else if (out_valid) begin
            open_q    <= open_q & ~out_eof;
            started_q <= 1'b1;
        end
    end

    // R8
    pay_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> open_q);

    // R8
    first_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !started_q) |-> out_sof);

    // R8
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && out_data == $past(in_data)));

    // R8
    marks_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    // R6
    accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    // R6
    dec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid));

    // R9
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |=> !out_valid);
endmodule

bind rxf_filter rxf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/sim_rxf_filter.sv
module sim_rxf_filter;
    localparam int CLK_P = 10;
    localparam logic [47:0] GL = 48'h02_11_22_33_44_55;
    localparam logic [47:0] GR = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [15:0] GT = 16'h88B5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [15:0] in_data = '0;
    logic [47:0] cfg_local_mac = '0, cfg_remote_mac = '0, reg_local_mac = '0, reg_remote_mac = '0;
    logic [15:0] cfg_ethertype = '0, reg_ethertype = '0;
    logic cfg_accept_bcast = 1'b0, cfg_any_source = 1'b0, reg_override = 1'b0;
    logic reg_accept_bcast = 1'b0, reg_any_source = 1'b0;
    logic out_valid, out_sof, out_eof, dec_valid, dec_accept;
    logic [15:0] out_data;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] fw [0:31];
    logic        fs [0:31];
    int flen, didx;

    always #(CLK_P/2) clk = ~clk;

    rxf_filter u0 (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_mac(input int at, input logic [47:0] m);
        for (int k = 0; k < 3; k++) fw[at+k] = m[47-16*k -: 16];
    endtask

    // header + optional tag + type + payload; decision index returned in didx
    task automatic build(input logic [47:0] dst, input logic [47:0] src, input bit vl,
                         input logic [15:0] typ, input int npay);
        int p;
        for (int k = 0; k < 32; k++) fs[k] = 1'b0;
        fs[0] = 1'b1;
        put_mac(0, dst);
        put_mac(3, src);
        p = 6;
        if (vl) begin
            fw[p] = 16'h8100; fw[p+1] = 16'h6005; p = p + 2;
        end
        fw[p] = typ; didx = p; p++;
        for (int k = 0; k < npay; k++) begin fw[p] = 16'h5000 + 16'(k*17 + npay); p++; end
        flen = p;
    endtask

    task automatic run_frame(input bit acc, input string tag);
        bit ed, eo, es, ee;
        int j;
        for (int i = 0; i <= flen; i++) begin
            @(negedge clk);
            if (i > 0) begin
                j  = i - 1;
                ed = (j == didx);
                eo = acc && (j > didx);
                es = (j == didx + 1);
                ee = eo && (j == flen - 1);
                check(dec_valid == ed && dec_accept == (ed && acc), ed ? tag : "R6",
                      {30'd0, dec_valid, dec_accept}, {30'd0, ed, ed && acc});
                check(out_valid == eo && (!eo || (out_data == fw[j] && out_sof == es && out_eof == ee)),
                      eo ? "R8" : "R9", {13'd0, out_valid, out_sof, out_eof, out_data},
                      {13'd0, eo, es && eo, ee, fw[j]});
            end
            if (i < flen) begin
                in_valid = 1'b1; in_data = fw[i]; in_sof = fs[i]; in_eof = (i == flen - 1);
            end else begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            end
        end
        @(negedge clk);
        check(!out_valid && !dec_valid, "R9", {30'd0, out_valid, dec_valid}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [47:0] dst, src;
        logic [15:0] typ;
        bit acc;
        string tag;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        check(!out_valid && !dec_valid, "R1", {30'd0, out_valid, dec_valid}, 32'd0);

        n = 0;
        for (int ov = 0; ov < 2; ov++)
        for (int bc = 0; bc < 2; bc++)
        for (int an = 0; an < 2; an++)
        for (int dk = 0; dk < 3; dk++)
        for (int sk = 0; sk < 2; sk++)
        for (int tk = 0; tk < 2; tk++)
        for (int vl = 0; vl < 2; vl++) begin
            @(negedge clk);
            // active set holds good values and the swept flags; the other set is wrong
            reg_override = ov[0];
            if (ov == 1) begin
                reg_local_mac = GL; reg_remote_mac = GR; reg_ethertype = GT;
                reg_accept_bcast = bc[0]; reg_any_source = an[0];
                cfg_local_mac = GL ^ 48'h1; cfg_remote_mac = GR ^ 48'h10; cfg_ethertype = GT ^ 16'h1;
                cfg_accept_bcast = ~bc[0]; cfg_any_source = ~an[0];
            end else begin
                cfg_local_mac = GL; cfg_remote_mac = GR; cfg_ethertype = GT;
                cfg_accept_bcast = bc[0]; cfg_any_source = an[0];
                reg_local_mac = GL ^ 48'h1; reg_remote_mac = GR ^ 48'h10; reg_ethertype = GT ^ 16'h1;
                reg_accept_bcast = ~bc[0]; reg_any_source = ~an[0];
            end
            dst = (dk == 0) ? GL : (dk == 1) ? 48'hFFFF_FFFF_FFFF : (GL ^ 48'h0100_0000);
            src = (sk == 0) ? GR : (GR ^ 48'h0000_0001_0000);
            typ = (tk == 0) ? GT : (GT ^ 16'h0101);
            acc = ((dk == 0) || (dk == 1 && bc == 1)) && (an == 1 || sk == 0) && (tk == 0);
            if (vl == 1)       tag = "R7";
            else if (ov == 1)  tag = "R10";
            else if (dk == 1)  tag = "R3";
            else if (sk == 1)  tag = "R4";
            else if (tk == 1)  tag = "R5";
            else               tag = "R2";
            build(dst, src, vl[0], typ, 1 + (n % 3));
            run_frame(acc, tag);
            n++;
        end

        // tagged frame whose inner type is 0x8100: compared as a plain type (R7)
        @(negedge clk);
        reg_override = 1'b0; cfg_local_mac = GL; cfg_remote_mac = GR;
        cfg_ethertype = 16'h8100; cfg_accept_bcast = 1'b0; cfg_any_source = 1'b0;
        build(GL, GR, 1'b1, 16'h8100, 2);
        run_frame(1'b1, "R7");
        cfg_ethertype = GT;

        // R11: frame ends inside the source address
        build(GL, GR, 1'b0, GT, 0);
        flen = 4; didx = 3;
        run_frame(1'b0, "R11");

        // R11: frame ends on the tag control word
        build(GL, GR, 1'b1, GT, 0);
        flen = 8; didx = 7;
        run_frame(1'b0, "R11");

        // R12: new start mark after four header words of an abandoned frame
        build(GL, GR, 1'b0, GT, 3);
        for (int k = flen - 1; k >= 0; k--) begin fw[k+4] = fw[k]; fs[k+4] = fs[k]; end
        for (int k = 0; k < 4; k++) begin fw[k] = 16'hFFFF; fs[k] = (k == 0); end
        flen = flen + 4; didx = didx + 4;
        run_frame(1'b1, "R12");

        // R12: restart in the middle of an accepted payload
        build(GL, GR, 1'b0, GT, 2);
        begin
            int base;
            base = flen;
            fw[base] = GL[47:32]; fs[base] = 1'b1;
            fw[base+1] = GL[31:16]; fw[base+2] = GL[15:0];
            fw[base+3] = GR[47:32]; fw[base+4] = GR[31:16]; fw[base+5] = GR[15:0];
            fw[base+6] = GT ^ 16'h0101; fw[base+7] = 16'h7777;
            flen = base + 8;
            // first frame's payload words before the restart are forwarded
            for (int i = 0; i <= flen; i++) begin
                @(negedge clk);
                if (i > 0) begin
                    bit ed, eo;
                    ed = (i-1 == didx) || (i-1 == base + 6);
                    eo = (i-1 > didx) && (i-1 < base);
                    check(dec_valid == ed && dec_accept == (i-1 == didx), "R12",
                          {30'd0, dec_valid, dec_accept}, {30'd0, ed, i-1 == didx});
                    check(out_valid == eo && (!eo || out_data == fw[i-1]), "R12",
                          {15'd0, out_valid, out_data}, {15'd0, eo, fw[i-1]});
                end
                if (i < flen) begin
                    in_valid = 1'b1; in_data = fw[i]; in_sof = fs[i]; in_eof = (i == flen - 1);
                end else begin
                    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                end
            end
        end

        // R9: re-armed after a drop, an ordinary frame is accepted
        build(GL, GR, 1'b0, GT, 2);
        run_frame(1'b1, "R9");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule